// File: doc/BRIEF.md
# AES-128 Round Key Generator

This block expands a 128-bit cipher key into the eleven round keys that an AES-128 data path consumes. A key enters through a valid/ready handshake. The block then presents round key 0, which is the key itself, followed by round keys 1 through 10 on a valid/ready output stream. Each key carries its round number. Every new round key is derived from the key before it and from a round constant that the block advances internally, so no table of keys or constants is stored.

The output obeys back-pressure. While `rk_valid` is high and `rk_ready` is low, the block holds the presented key and index and advances nothing. A round key is consumed on each cycle in which both signals are high. If the consumer keeps `rk_ready` high, the eleven keys leave on eleven consecutive cycles. Only one expansion is in flight at a time. `key_ready` is high exactly when the block is idle, and a key offered during an expansion is not taken.

When the parameter `STORE_EN` is set, every round key is also written into an eleven-entry store as it is produced. A combinational read port can then fetch any round key by index, for example so that a decryption path can walk the keys backwards.

Top module: `ks_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `rk_valid` is 0 and `key_ready` is 1.
- R2: When `key_valid` and `key_ready` are both high at a clock edge, on the next cycle `rk_valid` is 1, `rk_idx` is 0 and `rk_data` equals the accepted key.
- R3: Words are 32 bits with word 0 in `rk_data[127:96]`. Byte 0 of a word is its most significant byte. Round key r+1 is formed as follows. Let t be the bytes of word 3 of key r, rotated left by one byte (the byte order 1,2,3,0), with each byte then passed through the S-box. Word 0 of key r+1 is word 0 of key r XOR t XOR {rcon, 24'h0}. Each later word j of key r+1 is word j-1 of key r+1 XOR word j of key r. `rk_idx` rises by exactly one per consumed key and never exceeds 10.
- R4: The round constant used to form round key r is 01, 02, 04, 08, 10, 20, 40, 80, 1B, 36 for r = 1..10. Each constant is the previous one multiplied by 02 in GF(2^8).
- R5: The S-box of a byte is its multiplicative inverse in GF(2^8) modulo 0x11B, with 00 mapped to 00. The inverse then goes through an affine map whose output bit i is the XOR of inverse bits i, i+4, i+5, i+6 and i+7 (all modulo 8), XOR bit i of 0x63. This holds for all 256 byte values.
- R6: While `rk_valid` is 1 and `rk_ready` is 0, on the next cycle `rk_valid` stays 1 and `rk_idx` and `rk_data` are unchanged.
- R7: After round key 10 is consumed, on the next cycle `rk_valid` is 0 and `key_ready` is 1.
- R8: `key_ready` is 0 whenever `rk_valid` is 1. A key offered on `key_valid` during an expansion is ignored and does not alter the round keys being produced.
- R9: With `STORE_EN` set, `rd_key` returns round key `rd_idx` of the most recent expansion once that key has been presented. For `rd_idx` above 10, `rd_key` is zero.
- R10: For cipher key 2b7e151628aed2a6abf7158809cf4f3c, round key 10 is d014f9a8c9ee2589e13f0cc8b6630ca6. For the all-zero key, round key 10 is b4ef5bcb3e92e21123e951cf6f8f188e.
- R11: With `rk_ready` held at 1, the eleven round keys appear on eleven consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_valid | input | 1 | Cipher key offered |
| key_ready | output | 1 | Block idle and able to take a key |
| key_in | input | 128 | Cipher key, word 0 in the top bits |
| rk_valid | output | 1 | Round key presented |
| rk_ready | input | 1 | Consumer takes the presented round key |
| rk_idx | output | 4 | Round number of the presented key, 0..10 |
| rk_data | output | 128 | Presented round key |
| rd_idx | input | 4 | Store read index |
| rd_key | output | 128 | Stored round key at `rd_idx` |

## Verification
The checker assumes that `rst_n` is asserted before the first edge and that `key_valid` and `rk_ready` always carry defined levels. It does not require the offered key to stay stable. The start property compares against the key sampled at the accepting edge only, so a key that changes after acceptance is allowed. The bench drives all inputs on falling edges and releases reset before any key is offered. It exercises the output handshake with a steady ready, an alternating ready and an irregular ready. It also offers a rival key partway through each expansion, which probes the rule that keys offered while busy are ignored without breaking any assumption.

// File: rtl/ks_pkg.sv
package ks_pkg;
  localparam int WORD_W = 32;
  localparam int NWORD  = 4;
  localparam int KEY_W  = WORD_W * NWORD;
  localparam int NR     = 10;
  localparam int IDX_W  = $clog2(NR + 1);

  typedef logic [KEY_W-1:0] key_t;
  typedef logic [IDX_W-1:0] idx_t;

  // multiply in GF(2^8) reduced by x^8+x^4+x^3+x+1
  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1B : 8'h00);
    end
    return acc;
  endfunction

  // inverse as a^254; zero stays zero
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] r;
    logic [7:0] p;
    r = 8'h01;
    p = a;
    for (int i = 0; i < 8; i++) begin
      if (i != 0) r = gf_mul(r, p);
      p = gf_mul(p, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] affine(input logic [7:0] v);
    logic [7:0] o;
    for (int i = 0; i < 8; i++)
      o[i] = v[i] ^ v[(i+4)%8] ^ v[(i+5)%8] ^ v[(i+6)%8] ^ v[(i+7)%8];
    return o ^ 8'h63;
  endfunction

  function automatic logic [7:0] xtime(input logic [7:0] v);
    return {v[6:0], 1'b0} ^ (v[7] ? 8'h1B : 8'h00);
  endfunction
endpackage

// File: rtl/ks_sbox.sv
module ks_sbox
  import ks_pkg::*;
(
  input  logic [7:0] din,
  output logic [7:0] dout
);
  always_comb dout = affine(gf_inv(din));
endmodule

// File: rtl/ks_step.sv
module ks_step
  import ks_pkg::*;
(
  input  key_t       prev,
  input  logic [7:0] rcon,
  output key_t       next
);
  logic [WORD_W-1:0] w    [NWORD];
  logic [WORD_W-1:0] nw   [NWORD];
  logic [WORD_W-1:0] rot;
  logic [WORD_W-1:0] sub;

  for (genvar j = 0; j < NWORD; j++) begin : g_split
    assign w[j] = prev[KEY_W-1-WORD_W*j -: WORD_W];
    assign next[KEY_W-1-WORD_W*j -: WORD_W] = nw[j];
  end

  assign rot = {w[NWORD-1][WORD_W-9:0], w[NWORD-1][WORD_W-1 -: 8]};

  for (genvar b = 0; b < WORD_W/8; b++) begin : g_sub
    ks_sbox u_sbox (.din(rot[8*b +: 8]), .dout(sub[8*b +: 8]));
  end

  always_comb begin
    nw[0] = w[0] ^ sub ^ {rcon, {(WORD_W-8){1'b0}}};
    for (int j = 1; j < NWORD; j++) nw[j] = nw[j-1] ^ w[j];
  end
endmodule

// File: rtl/ks_store.sv
module ks_store
  import ks_pkg::*;
#(
  parameter int DEPTH = NR + 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  idx_t waddr,
  input  key_t wdata,
  input  idx_t raddr,
  output key_t rdata
);
  key_t mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we && (int'(waddr) < DEPTH)) begin
      mem[waddr] <= wdata;
    end
  end

  always_comb rdata = (int'(raddr) < DEPTH) ? mem[raddr] : '0;
endmodule

// File: rtl/ks_gen.sv
module ks_gen
  import ks_pkg::*;
#(
  parameter bit STORE_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_valid,
  output logic             key_ready,
  input  logic [KEY_W-1:0] key_in,
  output logic             rk_valid,
  input  logic             rk_ready,
  output logic [IDX_W-1:0] rk_idx,
  output logic [KEY_W-1:0] rk_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [KEY_W-1:0] rd_key
);
  localparam idx_t LAST = IDX_W'(NR);

  logic       busy;
  key_t       cur;
  key_t       nxt;
  idx_t       idx;
  logic [7:0] rcon;

  ks_step u_step (.prev(cur), .rcon(rcon), .next(nxt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cur  <= '0;
      idx  <= '0;
      rcon <= 8'h01;
    end else if (!busy) begin
      if (key_valid) begin
        busy <= 1'b1;
        cur  <= key_in;
        idx  <= '0;
        rcon <= 8'h01;
      end
    end else if (rk_ready) begin
      if (idx == LAST) begin
        busy <= 1'b0;
      end else begin
        cur  <= nxt;
        idx  <= idx + 1'b1;
        rcon <= xtime(rcon);
      end
    end
  end

  assign key_ready = !busy;
  assign rk_valid  = busy;
  assign rk_idx    = idx;
  assign rk_data   = cur;

  if (STORE_EN) begin : g_store
    ks_store u_store (
      .clk(clk), .rst_n(rst_n), .we(busy), .waddr(idx), .wdata(cur),
      .raddr(rd_idx), .rdata(rd_key)
    );
  end else begin : g_nostore
    assign rd_key = '0;
  end
endmodule

// File: rtl/ks_gen_chk.sv
module ks_gen_chk
  import ks_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             key_valid,
  input logic             key_ready,
  input logic [KEY_W-1:0] key_in,
  input logic             rk_valid,
  input logic             rk_ready,
  input logic [IDX_W-1:0] rk_idx,
  input logic [KEY_W-1:0] rk_data
);
  AST_START_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid && key_ready |=> rk_valid && rk_idx == '0 && rk_data == $past(key_in)); // R2
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rk_valid && rk_ready && rk_idx != IDX_W'(NR) |=> rk_valid && rk_idx == $past(rk_idx) + 1'b1); // R3
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rk_valid |-> rk_idx <= IDX_W'(NR)); // R3
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rk_valid && !rk_ready |=> rk_valid && $stable(rk_idx) && $stable(rk_data)); // R6
  AST_LAST_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rk_valid && rk_ready && rk_idx == IDX_W'(NR) |=> !rk_valid && key_ready); // R7
  AST_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    rk_valid |-> !key_ready); // R8
endmodule

bind ks_gen ks_gen_chk u_ks_gen_chk (
  .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_ready(key_ready),
  .key_in(key_in), .rk_valid(rk_valid), .rk_ready(rk_ready),
  .rk_idx(rk_idx), .rk_data(rk_data)
);

// File: tb/test_ks_gen.sv
module test_ks_gen;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         key_valid;
  logic         key_ready;
  logic [127:0] key_in;
  logic         rk_valid;
  logic         rk_ready;
  logic [3:0]   rk_idx;
  logic [127:0] rk_data;
  logic [3:0]   rd_idx;
  logic [127:0] rd_key;

  always #5 clk = ~clk;

  ks_gen i_ks_gen (
    .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_ready(key_ready),
    .key_in(key_in), .rk_valid(rk_valid), .rk_ready(rk_ready), .rk_idx(rk_idx),
    .rk_data(rk_data), .rd_idx(rd_idx), .rd_key(rd_key)
  );

  int n_chk  = 0;
  int n_fail = 0;
  logic [7:0]   sb [256];
  logic [127:0] ek [11];

  function automatic logic [7:0] mul2(input logic [7:0] a, input logic [7:0] b);
    int p = 0;
    int x = a;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (x << i);
    for (int i = 14; i >= 8; i--) if (p[i]) p = p ^ (32'h11B << (i - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] rotl(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  task automatic chk(input string rq, input logic [135:0] act, input logic [135:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic build(input logic [127:0] k);
    logic [7:0]  rc = 8'h01;
    logic [31:0] w3, t, n0, n1, n2, n3;
    ek[0] = k;
    for (int r = 1; r <= 10; r++) begin
      w3 = ek[r-1][31:0];
      t  = {sb[w3[23:16]], sb[w3[15:8]], sb[w3[7:0]], sb[w3[31:24]]} ^ {rc, 24'h0};
      n0 = ek[r-1][127:96] ^ t;
      n1 = n0 ^ ek[r-1][95:64];
      n2 = n1 ^ ek[r-1][63:32];
      n3 = n2 ^ ek[r-1][31:0];
      ek[r] = {n0, n1, n2, n3};
      rc = mul2(rc, 8'h02);
    end
  endtask

  // mode 0: ready held, 1: alternating, 2: irregular
  task automatic run(input logic [127:0] k, input int mode);
    int e = 0;
    int cyc = 0;
    logic rdy;
    build(k);
    key_valid = 1'b1;
    key_in    = k;
    chk("R8 idle ready", {135'b0, key_ready}, 136'd1);
    @(negedge clk);
    key_valid = 1'b0;
    forever begin
      // R2 (first), R3/R4/R5/R6 (later) - presented key matches model
      chk(e == 0 ? "R2" : "R3", {3'b0, rk_valid, rk_idx, rk_data}, {3'b0, 1'b1, 4'(e), ek[e]});
      case (mode)
        0:       rdy = 1'b1;
        1:       rdy = cyc[0];
        default: rdy = ((cyc * 7) % 3) != 0;
      endcase
      if (cyc == 3) begin
        key_valid = 1'b1;
        key_in    = ~k;
        chk("R8 busy", {135'b0, key_ready}, 136'd0);
      end
      rk_ready = rdy;
      @(negedge clk);
      key_valid = 1'b0;
      cyc++;
      if (rdy) begin
        if (e == 10) break;
        e++;
      end
    end
    rk_ready = 1'b0;
    chk("R7", {134'b0, rk_valid, key_ready}, 136'd1);
    if (mode == 0) chk("R11", 136'(cyc), 136'd11);
  endtask

  task automatic readback(input string rq);
    for (int i = 0; i < 12; i++) begin
      rd_idx = 4'(i);
      #1;
      chk(rq, {8'b0, rd_key}, {8'b0, (i < 11) ? ek[i] : 128'h0});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int a = 0; a < 256; a++) begin
      logic [7:0] inv = 8'h00;
      for (int b = 1; b < 256; b++) if (mul2(8'(a), 8'(b)) == 8'h01) inv = 8'(b);
      sb[a] = inv ^ rotl(inv, 1) ^ rotl(inv, 2) ^ rotl(inv, 3) ^ rotl(inv, 4) ^ 8'h63;
    end
    rst_n = 1'b0; key_valid = 1'b0; key_in = '0; rk_ready = 1'b0; rd_idx = '0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", {134'b0, rk_valid, key_ready}, 136'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {134'b0, rk_valid, key_ready}, 136'd1);

    run(128'h2b7e151628aed2a6abf7158809cf4f3c, 0);
    rd_idx = 4'd10; #1;
    chk("R10 known key", {8'b0, rd_key}, {8'b0, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6});
    readback("R9");
    @(negedge clk);
    run(128'h0, 1);
    rd_idx = 4'd10; #1;
    chk("R10 zero key", {8'b0, rd_key}, {8'b0, 128'hb4ef5bcb3e92e21123e951cf6f8f188e});
    @(negedge clk);
    run({128{1'b1}}, 2);
    readback("R9");
    @(negedge clk);
    // R5: word 3 sweeps all 256 byte values through the S-box, R4 over every round
    for (int g = 0; g < 64; g++) begin
      logic [31:0] w3 = {8'(4*g), 8'(4*g+1), 8'(4*g+2), 8'(4*g+3)};
      run({32'h9e3779b9 * 32'(g + 1), 32'h7f4a7c15 ^ 32'(g), 32'h0 - 32'(g), w3}, g % 3);
      @(negedge clk);
    end
    readback("R9");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule